// File: doc/BRIEF.md
# SD Host Interrupt Status Register

This block holds the sticky interrupt flags of an SD card host controller. Single-cycle event pulses come from the command path, the data path, the DMA engine, the buffer logic and card detection. A level input carries the card's own interrupt line, and an eight-bit error vector comes from the automatic stop-command logic. Each source sets one flag in a 32-bit status word. The flags stay set until software clears them through a small register port at offset 0x30. Software clears a flag by writing a one to its bit position. It can clear any combination of flags with one write.

The block also drives a single interrupt request. The request is the OR of all flags that are enabled in a 32-bit mask input. When a DMA failure is reported, the block stores the DMA address that comes with the failure, so that software can read back where the next fetch would have gone.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the flags start to respond two clock edges after the reset input goes high.

Top module: `sdh_irq_status`

## Requirements
- R1: While reset is asserted, the status word, the interrupt request and the captured DMA address are all zero.
- R2: A one-cycle pulse on an event input sets its flag on the next clock edge, and the flag stays set until it is cleared. The bit positions are: cmd_done 0, xfer_done 1, blk_gap 2, dma_evt 3, buf_wr_rdy 4, buf_rd_rdy 5, card_ins 6, card_rem 7, card_irq 8, cmd_timeout 16, cmd_crc_err 17, cmd_endbit_err 18, cmd_index_err 19, dat_timeout 20, dat_crc_err 21, dat_endbit_err 22, auto-stop error 24, dma_err 28.
- R3: A write with bus_sel and bus_we high and bus_addr equal to 0x30 clears, on the next edge, every flag whose bit in bus_wdata is one. Several flags can be cleared by one write. Flags whose bit in bus_wdata is zero are left unchanged.
- R4: A write to any other address, or an access with bus_we low, leaves every flag unchanged.
- R5: Bit positions that are not listed in R2 always read as zero, even after a write of all ones.
- R6: If a flag's source sets it in the same cycle as a write-one-to-clear of that flag, the flag stays set.
- R7: card_irq is sampled as a level on every cycle. While card_irq is high, the flag at bit 8 is set again on every edge, so a clear written while the line is still high has no lasting effect.
- R8: The flag at bit 24 is set on any cycle where acmd_err_vec is non-zero, and on any pulse of acmd_skipped.
- R9: A pulse on dma_err sets bit 28 and loads dma_addr into dma_err_addr on the same edge. Without a dma_err pulse, dma_err_addr holds its value.
- R10: irq is high exactly when the bitwise AND of the status word and irq_en is non-zero.
- R11: bus_rdata returns the flags as they stand at the start of the cycle when bus_sel is high and bus_addr is 0x30, and returns zero otherwise. A read does not change any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data; a one clears the flag at that bit |
| bus_rdata | output | 32 | Read data |
| cmd_done | input | 1 | Command complete pulse |
| xfer_done | input | 1 | Transfer complete pulse |
| blk_gap | input | 1 | Block gap stop pulse |
| dma_evt | input | 1 | DMA boundary event pulse |
| buf_wr_rdy | input | 1 | Buffer write ready pulse |
| buf_rd_rdy | input | 1 | Buffer read ready pulse |
| card_ins | input | 1 | Card inserted pulse |
| card_rem | input | 1 | Card removed pulse |
| card_irq | input | 1 | Card interrupt line, level |
| cmd_timeout | input | 1 | Command timeout pulse |
| cmd_crc_err | input | 1 | Command CRC error pulse |
| cmd_endbit_err | input | 1 | Command end-bit error pulse |
| cmd_index_err | input | 1 | Command index error pulse |
| dat_timeout | input | 1 | Data timeout pulse |
| dat_crc_err | input | 1 | Data CRC error pulse |
| dat_endbit_err | input | 1 | Zero seen at a data or CRC end-bit position, pulse |
| acmd_err_vec | input | 8 | Automatic stop-command error vector |
| acmd_skipped | input | 1 | Automatic stop command not issued, pulse |
| dma_err | input | 1 | DMA transfer failure pulse |
| dma_addr | input | 32 | DMA address that comes with a failure |
| irq_en | input | 32 | Interrupt enable mask |
| status | output | 32 | Current flags |
| irq | output | 1 | Combined interrupt request |
| dma_err_addr | output | 32 | Captured next-fetch address |

## Verification
The assertions assume that every event input except card_irq and acmd_err_vec is high for only one cycle at a time. They also assume that dma_addr is valid in the cycle where dma_err pulses, and that card_irq and acmd_err_vec may stay high for as long as they like. The stimulus drives each pulse for exactly one cycle between clock edges and then lowers it. Only the card line and the error vector are held across several edges, which exercises the cases where a flag is set again while it is being cleared. Every access, event and mask change is made only after the synchronised reset has been released.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
  localparam int unsigned STAT_W = 32;

  localparam int unsigned B_CMD_DONE  = 0;
  localparam int unsigned B_XFER_DONE = 1;
  localparam int unsigned B_BLK_GAP   = 2;
  localparam int unsigned B_DMA_EVT   = 3;
  localparam int unsigned B_BUF_WR    = 4;
  localparam int unsigned B_BUF_RD    = 5;
  localparam int unsigned B_CARD_INS  = 6;
  localparam int unsigned B_CARD_REM  = 7;
  localparam int unsigned B_CARD_IRQ  = 8;
  localparam int unsigned B_CMD_TMO   = 16;
  localparam int unsigned B_CMD_CRC   = 17;
  localparam int unsigned B_CMD_END   = 18;
  localparam int unsigned B_CMD_IDX   = 19;
  localparam int unsigned B_DAT_TMO   = 20;
  localparam int unsigned B_DAT_CRC   = 21;
  localparam int unsigned B_DAT_END   = 22;
  localparam int unsigned B_ACMD_ERR  = 24;
  localparam int unsigned B_DMA_ERR   = 28;

  typedef logic [STAT_W-1:0] stat_t;

  localparam stat_t IMPL_MASK = stat_t'((32'h1 << B_CMD_DONE) | (32'h1 << B_XFER_DONE) |
    (32'h1 << B_BLK_GAP) | (32'h1 << B_DMA_EVT) | (32'h1 << B_BUF_WR) |
    (32'h1 << B_BUF_RD) | (32'h1 << B_CARD_INS) | (32'h1 << B_CARD_REM) |
    (32'h1 << B_CARD_IRQ) | (32'h1 << B_CMD_TMO) | (32'h1 << B_CMD_CRC) |
    (32'h1 << B_CMD_END) | (32'h1 << B_CMD_IDX) | (32'h1 << B_DAT_TMO) |
    (32'h1 << B_DAT_CRC) | (32'h1 << B_DAT_END) | (32'h1 << B_ACMD_ERR) |
    (32'h1 << B_DMA_ERR));
endpackage

// File: rtl/sdh_irq_rst_sync.sv
module sdh_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sdh_irq_srcmap.sv
module sdh_irq_srcmap
  import sdh_irq_pkg::*;
#(
  parameter int unsigned ACMD_W = 8
) (
  input  logic              cmd_done,
  input  logic              xfer_done,
  input  logic              blk_gap,
  input  logic              dma_evt,
  input  logic              buf_wr_rdy,
  input  logic              buf_rd_rdy,
  input  logic              card_ins,
  input  logic              card_rem,
  input  logic              card_irq,
  input  logic              cmd_timeout,
  input  logic              cmd_crc_err,
  input  logic              cmd_endbit_err,
  input  logic              cmd_index_err,
  input  logic              dat_timeout,
  input  logic              dat_crc_err,
  input  logic              dat_endbit_err,
  input  logic [ACMD_W-1:0] acmd_err_vec,
  input  logic              acmd_skipped,
  input  logic              dma_err,
  output stat_t             set_vec
);
  always_comb begin
    set_vec             = '0;
    set_vec[B_CMD_DONE]  = cmd_done;
    set_vec[B_XFER_DONE] = xfer_done;
    set_vec[B_BLK_GAP]   = blk_gap;
    set_vec[B_DMA_EVT]   = dma_evt;
    set_vec[B_BUF_WR]    = buf_wr_rdy;
    set_vec[B_BUF_RD]    = buf_rd_rdy;
    set_vec[B_CARD_INS]  = card_ins;
    set_vec[B_CARD_REM]  = card_rem;
    set_vec[B_CARD_IRQ]  = card_irq;
    set_vec[B_CMD_TMO]   = cmd_timeout;
    set_vec[B_CMD_CRC]   = cmd_crc_err;
    set_vec[B_CMD_END]   = cmd_endbit_err;
    set_vec[B_CMD_IDX]   = cmd_index_err;
    set_vec[B_DAT_TMO]   = dat_timeout;
    set_vec[B_DAT_CRC]   = dat_crc_err;
    set_vec[B_DAT_END]   = dat_endbit_err;
    set_vec[B_ACMD_ERR]  = (|acmd_err_vec) | acmd_skipped;
    set_vec[B_DMA_ERR]   = dma_err;
  end
endmodule

// File: rtl/sdh_irq_flag.sv
module sdh_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/sdh_irq_dmacap.sv
module sdh_irq_dmacap #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (cap_en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
  import sdh_irq_pkg::*;
#(
  parameter int unsigned           BUS_AW     = 8,
  parameter logic [BUS_AW-1:0]     REG_OFFSET = 8'h30,
  parameter int unsigned           ACMD_W     = 8,
  parameter int unsigned           DMA_AW     = 32,
  parameter int unsigned           SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              cmd_done,
  input  logic              xfer_done,
  input  logic              blk_gap,
  input  logic              dma_evt,
  input  logic              buf_wr_rdy,
  input  logic              buf_rd_rdy,
  input  logic              card_ins,
  input  logic              card_rem,
  input  logic              card_irq,
  input  logic              cmd_timeout,
  input  logic              cmd_crc_err,
  input  logic              cmd_endbit_err,
  input  logic              cmd_index_err,
  input  logic              dat_timeout,
  input  logic              dat_crc_err,
  input  logic              dat_endbit_err,
  input  logic [ACMD_W-1:0] acmd_err_vec,
  input  logic              acmd_skipped,
  input  logic              dma_err,
  input  logic [DMA_AW-1:0] dma_addr,
  input  logic [31:0]       irq_en,
  output logic [31:0]       status,
  output logic              irq,
  output logic [DMA_AW-1:0] dma_err_addr
);
  logic  rst_sync_n;
  stat_t set_vec;
  stat_t clr_vec;
  stat_t flags;
  logic  reg_hit;
  logic  wr_hit;

  sdh_irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sdh_irq_srcmap #(.ACMD_W(ACMD_W)) u_map (
    .cmd_done       (cmd_done),
    .xfer_done      (xfer_done),
    .blk_gap        (blk_gap),
    .dma_evt        (dma_evt),
    .buf_wr_rdy     (buf_wr_rdy),
    .buf_rd_rdy     (buf_rd_rdy),
    .card_ins       (card_ins),
    .card_rem       (card_rem),
    .card_irq       (card_irq),
    .cmd_timeout    (cmd_timeout),
    .cmd_crc_err    (cmd_crc_err),
    .cmd_endbit_err (cmd_endbit_err),
    .cmd_index_err  (cmd_index_err),
    .dat_timeout    (dat_timeout),
    .dat_crc_err    (dat_crc_err),
    .dat_endbit_err (dat_endbit_err),
    .acmd_err_vec   (acmd_err_vec),
    .acmd_skipped   (acmd_skipped),
    .dma_err        (dma_err),
    .set_vec        (set_vec)
  );

  always_comb begin
    reg_hit = bus_sel && (bus_addr == REG_OFFSET);
    wr_hit  = reg_hit && bus_we;
    clr_vec = wr_hit ? (bus_wdata & IMPL_MASK) : '0;
  end

  for (genvar gi = 0; gi < STAT_W; gi++) begin : g_bit
    if (IMPL_MASK[gi]) begin : g_impl
      sdh_irq_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .set_i  (set_vec[gi]),
        .clr_i  (clr_vec[gi]),
        .flag_o (flags[gi])
      );
    end else begin : g_rsvd
      assign flags[gi] = 1'b0;
    end
  end

  sdh_irq_dmacap #(.ADDR_W(DMA_AW)) u_cap (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cap_en (dma_err),
    .addr_i (dma_addr),
    .addr_o (dma_err_addr)
  );

  always_comb begin
    status    = flags;
    irq       = |(flags & irq_en);
    bus_rdata = reg_hit ? flags : '0;
  end
endmodule

// File: rtl/sdh_irq_status_chk.sv
module sdh_irq_status_chk
  import sdh_irq_pkg::*;
#(
  parameter int unsigned DMA_AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_sync_n,
  input logic [31:0]       status,
  input logic              irq,
  input logic [31:0]       set_vec,
  input logic              wr_hit,
  input logic [31:0]       bus_wdata,
  input logic              card_irq,
  input logic              dma_err,
  input logic [DMA_AW-1:0] dma_addr,
  input logic [DMA_AW-1:0] dma_err_addr
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_zero_r1: assert (status == '0 && !irq && dma_err_addr == '0);
    end
  end

  p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (status & ~IMPL_MASK) == '0);

  p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_hit |=> ((status & $past(bus_wdata & ~set_vec)) == '0));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_hit |=> ((status & $past(status)) == $past(status)));

  p_cint_level_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    card_irq |=> status[B_CARD_IRQ]);

  p_dma_cap_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dma_err |=> (dma_err_addr == $past(dma_addr)));

  p_dma_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !dma_err |=> $stable(dma_err_addr));

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (status == '0) |-> !irq);
endmodule

bind sdh_irq_status sdh_irq_status_chk #(.DMA_AW(DMA_AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_sync_n   (rst_sync_n),
  .status       (status),
  .irq          (irq),
  .set_vec      (set_vec),
  .wr_hit       (wr_hit),
  .bus_wdata    (bus_wdata),
  .card_irq     (card_irq),
  .dma_err      (dma_err),
  .dma_addr     (dma_addr),
  .dma_err_addr (dma_err_addr)
);

// File: tb/sdh_irq_status_tb.sv
`timescale 1ns/1ps
module sdh_irq_status_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic bus_sel, bus_we;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic cmd_done, xfer_done, blk_gap, dma_evt, buf_wr_rdy, buf_rd_rdy;
  logic card_ins, card_rem, card_irq;
  logic cmd_timeout, cmd_crc_err, cmd_endbit_err, cmd_index_err;
  logic dat_timeout, dat_crc_err, dat_endbit_err;
  logic [7:0] acmd_err_vec;
  logic acmd_skipped, dma_err;
  logic [31:0] dma_addr, irq_en, status, dma_err_addr;
  logic irq;

  sdh_irq_status u_dut (.*);

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  logic [31:0] m_flags = '0;
  logic [31:0] m_addr = '0;
  localparam logic [31:0] MASK = 32'h117F_01FF;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ev_vec();
    logic [31:0] v = '0;
    v[0] = cmd_done;    v[1] = xfer_done;  v[2] = blk_gap;   v[3] = dma_evt;
    v[4] = buf_wr_rdy;  v[5] = buf_rd_rdy; v[6] = card_ins;  v[7] = card_rem;
    v[8] = card_irq;    v[16] = cmd_timeout; v[17] = cmd_crc_err;
    v[18] = cmd_endbit_err; v[19] = cmd_index_err; v[20] = dat_timeout;
    v[21] = dat_crc_err; v[22] = dat_endbit_err;
    v[24] = (acmd_err_vec != 0) || acmd_skipped;
    v[28] = dma_err;
    return v;
  endfunction

  task automatic tick();
    logic [31:0] clr;
    @(posedge clk);
    clr = (bus_sel && bus_we && bus_addr == 8'h30) ? bus_wdata : '0;
    if (!rst_n) begin
      m_flags = '0;
      m_addr  = '0;
    end else begin
      m_flags = (ev_vec() | (m_flags & ~clr)) & MASK;
      if (dma_err) m_addr = dma_addr;
    end
    @(negedge clk);
    chk("R2 status vs model", status, m_flags);
    chk("R10 irq vs model", {31'b0, irq}, {31'b0, |(m_flags & irq_en)});
    chk("R9 captured address", dma_err_addr, m_addr);
    chk("R11 read data", bus_rdata, (bus_sel && bus_addr == 8'h30) ? m_flags : 32'h0);
  endtask

  task automatic clear_pulses();
    {cmd_done, xfer_done, blk_gap, dma_evt, buf_wr_rdy, buf_rd_rdy, card_ins, card_rem,
     cmd_timeout, cmd_crc_err, cmd_endbit_err, cmd_index_err, dat_timeout, dat_crc_err,
     dat_endbit_err, acmd_skipped, dma_err} = '0;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic pulse(input int idx);
    case (idx)
      0: cmd_done = 1;        1: xfer_done = 1;      2: blk_gap = 1;
      3: dma_evt = 1;         4: buf_wr_rdy = 1;     5: buf_rd_rdy = 1;
      6: card_ins = 1;        7: card_rem = 1;       8: card_irq = 1;
      9: cmd_timeout = 1;     10: cmd_crc_err = 1;   11: cmd_endbit_err = 1;
      12: cmd_index_err = 1;  13: dat_timeout = 1;   14: dat_crc_err = 1;
      15: dat_endbit_err = 1; 16: acmd_skipped = 1;  default: dma_err = 1;
    endcase
    tick();
    clear_pulses();
    card_irq = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic we);
    bus_sel = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    tick();
    clear_pulses();
  endtask

  logic done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; clear_pulses(); card_irq = 0; acmd_err_vec = '0;
    bus_addr = '0; bus_wdata = '0; dma_addr = '0; irq_en = '1;
    repeat (3) tick();
    chk("R1 reset status", status, 32'h0);
    chk("R1 reset irq", {31'b0, irq}, 32'h0);
    chk("R1 reset dma addr", dma_err_addr, 32'h0);
    rst_n = 1;
    repeat (4) tick();

    for (int i = 0; i < 18; i++) begin
      if (i == 17) dma_addr = 32'hCAFE_0100;
      pulse(i);
    end
    chk("R2 all event flags", status, MASK);

    wr(8'h34, 32'hFFFF_FFFF, 1);
    chk("R4 other address", status, MASK);
    wr(8'h30, 32'hFFFF_FFFF, 0);
    chk("R4 read no clear", status, MASK);
    wr(8'h30, 32'h0000_0003, 1);
    chk("R3 partial clear", status, MASK & ~32'h3);
    wr(8'h30, 32'h0, 1);
    chk("R3 zero write", status, MASK & ~32'h3);
    wr(8'h30, 32'hFFFF_FFFF, 1);
    chk("R3 clear all", status, 32'h0);
    chk("R5 reserved zero", status & ~MASK, 32'h0);

    cmd_done = 1;
    wr(8'h30, 32'h1, 1);
    chk("R6 set wins", status & 32'h1, 32'h1);
    wr(8'h30, 32'h1, 1);

    card_irq = 1;
    tick();
    wr(8'h30, 32'h100, 1);
    chk("R7 level resets", status & 32'h100, 32'h100);
    card_irq = 0;
    wr(8'h30, 32'h100, 1);
    chk("R7 cleared after drop", status & 32'h100, 32'h0);

    acmd_err_vec = 8'h10;
    tick();
    acmd_err_vec = 8'h00;
    chk("R8 vector sets", status & 32'h0100_0000, 32'h0100_0000);
    wr(8'h30, 32'h0100_0000, 1);
    chk("R8 cleared", status & 32'h0100_0000, 32'h0);
    pulse(16);
    chk("R8 skipped sets", status & 32'h0100_0000, 32'h0100_0000);
    acmd_err_vec = 8'h81;
    wr(8'h30, 32'h0100_0000, 1);
    chk("R8 held vector", status & 32'h0100_0000, 32'h0100_0000);
    acmd_err_vec = 8'h00;
    wr(8'h30, 32'hFFFF_FFFF, 1);

    dma_addr = 32'h1234_5678;
    pulse(17);
    chk("R9 capture", dma_err_addr, 32'h1234_5678);
    dma_addr = 32'hDEAD_BEEF;
    tick();
    chk("R9 hold", dma_err_addr, 32'h1234_5678);
    dma_addr = 32'h0000_0A00;
    pulse(17);
    chk("R9 recapture", dma_err_addr, 32'h0000_0A00);
    wr(8'h30, 32'hFFFF_FFFF, 1);

    pulse(13);
    irq_en = 32'h0; tick();
    chk("R10 masked", {31'b0, irq}, 32'h0);
    irq_en = 32'h0010_0000; tick();
    chk("R10 enabled", {31'b0, irq}, 32'h1);
    irq_en = ~32'h0010_0000; tick();
    chk("R10 other bits", {31'b0, irq}, 32'h0);
    irq_en = '1;

    bus_sel = 1; bus_we = 0; bus_addr = 8'h30;
    repeat (3) tick();
    chk("R11 read value", bus_rdata, 32'h0010_0000);
    bus_addr = 8'h2C; tick();
    chk("R11 unmapped zero", bus_rdata, 32'h0);
    clear_pulses();
    chk("R11 no side effect", status, 32'h0010_0000);
    tick();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule